// File: doc/BRIEF.md
# Output Port with Flow-Control Sources

This block drives a bank of general-purpose output pins for a serial controller. A port register holds one bit per pin. Software changes it through two write commands. One command turns on every bit where the data word has a one, and the other turns those bits off. Bits whose data bit is zero keep their value. When the port register feeds a pin, the pin shows the inverse of the register bit. After reset the register is all zeros, so every register-sourced pin sits high.

A source-select register picks, for each pin from 2 upward, either the port register or an internal signal. Pin 3's internal signal is the counter/timer waveform. Pin 1 always follows the port register.

Pin 0 can be handed to the receiver as an automatic request-to-send line. In that mode the line goes high (not ready) when the receive FIFO is full and the start bit of one more character is seen. It returns low once the FIFO is no longer full.

A clear-to-send input can also be set up to gate the transmitter. While gating is on, a high input withdraws permission to begin a new character. The serializer itself finishes the character in progress.

Top module: `outport_top`

## Requirements
- R1: After reset the port register, the source-select register and the request-to-send flag are all zero. With automatic request-to-send off, every pin reads 1.
- R2: A write to address 0xE sets each port register bit whose data bit is 1. All other bits keep their value. The change is visible on the pins from the next clock edge.
- R3: A write to address 0xF clears each port register bit whose data bit is 1. All other bits keep their value.
- R4: A pin fed by the port register drives the inverse of its register bit. Pin 1 is always fed this way.
- R5: A write to address 0xD loads data bits 7..2 into the source-select register. Bit k=1 routes internal source altSrc[k] to pin k, not inverted. Bit k=0 routes the port register. Data bits 1..0 are ignored.
- R6: altSrc[3] carries the counter/timer waveform. Pin 3 follows it cycle by cycle while selected.
- R7: With rtsAutoEn=1, pin 0 shows the request-to-send flag. The flag goes to 1 at the clock edge where rxFifoFull and rxStartSeen are both 1.
- R8: With rtsAutoEn=1, the flag returns to 0 at the first clock edge where rxFifoFull is 0.
- R9: The flag holds while the FIFO stays full and no start bit is seen. It is cleared whenever rtsAutoEn=0, and pin 0 then follows the port register.
- R10: With ctsGateEn=1, txAllow is the inverse of ctsIn. A high ctsIn forbids starting a new character.
- R11: With ctsGateEn=0, txAllow is 1 whatever ctsIn is.
- R12: A write to any address other than 0xD, 0xE or 0xF changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | CPU write strobe, one cycle |
| wrAddr | input | 4 | Write address |
| wrData | input | 8 | Write data |
| altSrc | input | 6 | Internal sources for pins 7..2 (bit 3 is the counter/timer waveform) |
| rtsAutoEn | input | 1 | Hand pin 0 to the receiver's request-to-send logic |
| rxFifoFull | input | 1 | Receive FIFO full |
| rxStartSeen | input | 1 | Pulse: start bit of an incoming character detected |
| ctsGateEn | input | 1 | Enable clear-to-send gating of the transmitter |
| ctsIn | input | 1 | Clear-to-send input, low means go |
| txAllow | output | 1 | Transmitter may begin a new character |
| pins | output | 8 | Output pins |

## Verification
Several properties are checked on every cycle. The set and clear commands must give exactly the OR and AND-NOT of the old register with the data. All other writes must leave the register untouched. The request-to-send flag must rise on full-plus-start and fall on not-full. The transmit permission must obey the gate. Only the bench scenarios can show the pin-level results: the inversion of register-sourced pins, the per-pin routing of internal sources after a source-select write, pin 3 tracking the waveform, and pin 0 falling back to the register when automatic mode is dropped.

// File: rtl/outport_pkg.sv
package outport_pkg;

  // Strobes from control to datapath, valid for one cycle.
  typedef struct packed {
    logic setBits;   // OR data into port register
    logic clrBits;   // AND-NOT data into port register
    logic cfgLoad;   // load source-select register
    logic rtsRaise;  // raise request-to-send flag
    logic rtsDrop;   // drop request-to-send flag
  } portStrobes_t;

endpackage

// File: rtl/outport_ctrl.sv
module outport_ctrl
  import outport_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] SET_ADDR = 'hE,
  parameter logic [ADDR_W-1:0] CLR_ADDR = 'hF,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 'hD
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              rtsAutoEn,
  input  logic              rxFifoFull,
  input  logic              rxStartSeen,
  input  logic              ctsGateEn,
  input  logic              ctsIn,
  output portStrobes_t      stb,
  output logic              txAllow
);

  logic fullAndStart;

  always_comb begin
    fullAndStart = rxFifoFull && rxStartSeen;
    stb.setBits  = wrEn && (wrAddr == SET_ADDR);
    stb.clrBits  = wrEn && (wrAddr == CLR_ADDR);
    stb.cfgLoad  = wrEn && (wrAddr == CFG_ADDR);
    stb.rtsRaise = rtsAutoEn && fullAndStart;
    stb.rtsDrop  = !rtsAutoEn || !rxFifoFull;
  end

  // A high clear-to-send blocks only the start of the next character.
  always_comb begin
    txAllow = ctsGateEn ? !ctsIn : 1'b1;
  end

endmodule

// File: rtl/outport_dp.sv
module outport_dp
  import outport_pkg::*;
#(
  parameter int NPINS     = 8,
  parameter int FIRST_CFG = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  portStrobes_t             stb,
  input  logic [NPINS-1:0]         wrData,
  input  logic [NPINS-1:FIRST_CFG] altSrc,
  input  logic                     rtsAutoEn,
  output logic [NPINS-1:0]         pins
);

  localparam int CFG_W = NPINS - FIRST_CFG;

  logic [NPINS-1:0]         portReg;
  logic [NPINS-1:FIRST_CFG] cfgReg;
  logic                     rtsFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      portReg <= '0;
    end else if (stb.setBits) begin
      portReg <= portReg | wrData;
    end else if (stb.clrBits) begin
      portReg <= portReg & ~wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg <= '0;
    end else if (stb.cfgLoad) begin
      cfgReg <= wrData[NPINS-1:FIRST_CFG];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rtsFlag <= 1'b0;
    end else if (stb.rtsRaise) begin
      rtsFlag <= 1'b1;
    end else if (stb.rtsDrop) begin
      rtsFlag <= 1'b0;
    end
  end

  for (genvar k = 0; k < NPINS; k++) begin : g_pin
    if (k == 0) begin : g_rts
      assign pins[k] = rtsAutoEn ? rtsFlag : ~portReg[k];
    end else if (k < FIRST_CFG) begin : g_fixed
      assign pins[k] = ~portReg[k];
    end else begin : g_sel
      assign pins[k] = cfgReg[k] ? altSrc[k] : ~portReg[k];
    end
  end

  if (CFG_W < 1) begin : g_badcfg
    initial $error("outport_dp: no selectable pins");
  end

endmodule

// File: rtl/outport_top.sv
module outport_top
  import outport_pkg::*;
#(
  parameter int NPINS     = 8,
  parameter int FIRST_CFG = 2,
  parameter int ADDR_W    = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [NPINS-1:0]         wrData,
  input  logic [NPINS-1:FIRST_CFG] altSrc,
  input  logic                     rtsAutoEn,
  input  logic                     rxFifoFull,
  input  logic                     rxStartSeen,
  input  logic                     ctsGateEn,
  input  logic                     ctsIn,
  output logic                     txAllow,
  output logic [NPINS-1:0]         pins
);

  portStrobes_t stb;

  outport_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .rtsAutoEn(rtsAutoEn),
    .rxFifoFull(rxFifoFull), .rxStartSeen(rxStartSeen),
    .ctsGateEn(ctsGateEn), .ctsIn(ctsIn), .stb(stb), .txAllow(txAllow)
  );

  outport_dp #(.NPINS(NPINS), .FIRST_CFG(FIRST_CFG)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .altSrc(altSrc),
    .rtsAutoEn(rtsAutoEn), .pins(pins)
  );

endmodule

// File: rtl/outport_chk.sv
module outport_chk #(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [NPINS-1:0]  wrData,
  input logic              rtsAutoEn,
  input logic              rxFifoFull,
  input logic              rxStartSeen,
  input logic              ctsGateEn,
  input logic              ctsIn,
  input logic              txAllow,
  input logic [NPINS-1:0]  pins,
  input logic [NPINS-1:0]  portReg,
  input logic              rtsFlag
);

  logic isSet, isClr;
  assign isSet = wrEn && (wrAddr == ADDR_W'('hE));
  assign isClr = wrEn && (wrAddr == ADDR_W'('hF));

  AST_SET_BITS: assert property (@(posedge clk) disable iff (!rstN)
    isSet |=> portReg == ($past(portReg) | $past(wrData)));                  // R2
  AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rstN)
    isClr |=> portReg == ($past(portReg) & ~$past(wrData)));                 // R3
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(isSet || isClr) |=> $stable(portReg));                                // R12
  AST_RTS_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    (rtsAutoEn && rxFifoFull && rxStartSeen) |=> (rtsFlag && (!rtsAutoEn || pins[0]))); // R7
  AST_RTS_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (rtsAutoEn && !rxFifoFull) |=> !rtsFlag);                               // R8
  AST_RTS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !rtsAutoEn |=> !rtsFlag);                                               // R9
  AST_CTS_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (ctsGateEn && ctsIn) |-> !txAllow);                                     // R10
  AST_CTS_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
    !ctsGateEn |-> txAllow);                                                // R11

endmodule

bind outport_top outport_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .rtsAutoEn(rtsAutoEn), .rxFifoFull(rxFifoFull), .rxStartSeen(rxStartSeen),
  .ctsGateEn(ctsGateEn), .ctsIn(ctsIn), .txAllow(txAllow), .pins(pins),
  .portReg(u_dp.portReg), .rtsFlag(u_dp.rtsFlag)
);

// File: tb/sim_outport_top.sv
`timescale 1ns/100ps
module sim_outport_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:2] altSrc = '0;
  logic       rtsAutoEn = 1'b0, rxFifoFull = 1'b0, rxStartSeen = 1'b0;
  logic       ctsGateEn = 1'b0, ctsIn = 1'b0;
  logic       txAllow;
  logic [7:0] pins;

  always #2.5 clk = ~clk;

  outport_top u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .altSrc(altSrc), .rtsAutoEn(rtsAutoEn), .rxFifoFull(rxFifoFull),
    .rxStartSeen(rxStartSeen), .ctsGateEn(ctsGateEn), .ctsIn(ctsIn),
    .txAllow(txAllow), .pins(pins)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] qPins[$];
  logic       qTx[$];
  string      qTag[$];

  // Bench model state
  logic [7:0] mPort = '0;
  logic [7:2] mCfg = '0;
  logic       mRts = 1'b0;

  function automatic logic [7:0] expPins();
    logic [7:0] p;
    p[0] = rtsAutoEn ? mRts : ~mPort[0];
    p[1] = ~mPort[1];
    for (int k = 2; k < 8; k++) p[k] = mCfg[k] ? altSrc[k] : ~mPort[k];
    return p;
  endfunction

  // Driver: lets one clock edge pass, updates the model, queues the expected outputs
  task automatic step(input string tag);
    @(posedge clk);
    if (rstN) begin
      if (wrEn && wrAddr == 4'hE) mPort = mPort | wrData;
      else if (wrEn && wrAddr == 4'hF) mPort = mPort & ~wrData;
      else if (wrEn && wrAddr == 4'hD) mCfg = wrData[7:2];
      if (!rtsAutoEn) mRts = 1'b0;
      else if (rxFifoFull && rxStartSeen) mRts = 1'b1;
      else if (!rxFifoFull) mRts = 1'b0;
    end
    qPins.push_back(expPins());
    qTx.push_back(ctsGateEn ? ~ctsIn : 1'b1);
    qTag.push_back(tag);
    @(negedge clk); #1;
    wrEn = 1'b0; rxStartSeen = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input string tag);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    step(tag);
  endtask

  // Monitor: compares at the falling edge
  always @(negedge clk) begin
    if (qPins.size() > 0) begin
      logic [7:0] ep;
      logic et;
      string tg;
      ep = qPins.pop_front(); et = qTx.pop_front(); tg = qTag.pop_front();
      checks++;
      if (pins !== ep || txAllow !== et) begin
        errors++;
        $display("FAIL %s pins=%h txAllow=%b expected pins=%h txAllow=%b",
                 tg, pins, txAllow, ep, et);
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    step("R1 reset");
    rstN = 1'b1;
    step("R1 idle after reset");
    wr(4'hE, 8'hA5, "R2 set A5 / R4 inverted pins");
    wr(4'hE, 8'h10, "R2 set 10 keeps others");
    wr(4'hF, 8'h81, "R3 clear 81 keeps others");
    wr(4'hF, 8'h00, "R3 clear with zero data");
    wr(4'h3, 8'hFF, "R12 write to other address");
    wr(4'hC, 8'h00, "R12 second unused address");
    wr(4'hE, 8'hFF, "R2 set all");
    wr(4'hF, 8'hFF, "R3 clear all / R4");
    wr(4'hE, 8'h3C, "R2 set 3C");
    altSrc = 6'b000000;
    wr(4'hD, 8'h0B, "R5 select pin3 internal, low bits ignored");
    altSrc = 6'b000010; step("R6 pin3 follows waveform high");
    altSrc = 6'b000000; step("R6 pin3 follows waveform low");
    altSrc = 6'b101011; step("R5 unselected pins ignore internal sources");
    wr(4'hD, 8'hFC, "R5 select all upper pins");
    altSrc = 6'b010100; step("R5 internal pattern non-inverted");
    wr(4'hD, 8'h00, "R5 back to register");
    rtsAutoEn = 1'b1; step("R9 auto rts idle low");
    rxFifoFull = 1'b1; step("R9 full without start keeps low");
    rxStartSeen = 1'b1; step("R7 full plus start raises rts");
    step("R9 flag holds while full");
    rxFifoFull = 1'b0; step("R8 not full drops rts");
    rxFifoFull = 1'b1; rxStartSeen = 1'b1; step("R7 raise again");
    rtsAutoEn = 1'b0; step("R9 auto off: pin0 from register");
    rtsAutoEn = 1'b1; step("R9 flag cleared after auto off");
    rxFifoFull = 1'b0; rtsAutoEn = 1'b0;
    ctsGateEn = 1'b0; ctsIn = 1'b1; step("R11 gate off, cts high");
    ctsGateEn = 1'b1; step("R10 gate on, cts high blocks");
    ctsIn = 1'b0; step("R10 gate on, cts low allows");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule